// File: doc/BRIEF.md
# Half-Duplex Serial Transmitter with Line-Driver Enable

This block is the transmit half of an asynchronous serial port. It accepts one byte at a time into a single-entry holding register and moves it into a shift register, which sends it on `txd` as a start bit, eight data bits (least significant first), a parity bit and a stop bit. A one-cycle `baudTick` strobe, generated elsewhere, marks every bit boundary. After each character the transmitter can hold the line high for a configurable number of extra idle bit periods, called the guard time, before the next character starts.

Two status flags describe its state. `txReady` means the holding register can take a byte. `txEmpty` means nothing is left to send: the holding register is empty, the shift register is idle and no guard time is still running. When the mode field selects half-duplex bus operation, `rts` drives the enable pin of an external line driver. It is the inverse of `txEmpty`, so the driver stays on through the guard time and turns off only after the line has settled. In any other mode, `rts` simply follows a level supplied by software.

Top module: `hdx_uart_tx`

## Requirements
- R1: Bus-driver mode is active only when the 4-bit `modeSel` equals 4'h1. Every other value, including nonzero values such as 4'h9, selects plain mode.
- R2: In bus-driver mode, `rts` equals the inverse of `txEmpty` in every cycle.
- R3: With a nonzero guard time, `txEmpty` stays low and `rts` stays high through the whole guard time. Both change only after the baud tick that ends the last guard period.
- R4: A frame on `txd` is a low start bit, data bits 0 through 7, the parity bit and a high stop bit. Each bit lasts from one baud tick to the next, and `txd` changes only in the cycle after a baud tick.
- R5: A guard value of N (sampled when the character is loaded) puts N high bit periods after the stop bit, before the next start bit or before the transmitter reports empty.
- R6: `txReady` is low from the cycle after a write to the holding register. It goes high again in the cycle after that byte moves into the shift register, which happens on the first baud tick at which the shifter is free.
- R7: `txEmpty` is high only when the holding register is empty, no frame is being sent and no guard time remains. It is low from the cycle after a write.
- R8: With a guard value of 0, a queued character's start bit follows the previous stop bit with no idle period.
- R9: The parity bit makes the count of ones over the data and parity bits even when `oddParity` is 0 and odd when it is 1. `oddParity` is sampled when the byte is loaded.
- R10: A byte written while a guard time is running starts only after the guard time ends. In bus-driver mode `rts` stays high without a break across both characters.
- R11: In plain mode, `rts` equals `manualRts` in every cycle.
- R12: During and just after reset, `txd` is 1, `txReady` is 1 and `txEmpty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle strobe at every bit boundary |
| wrStrobe | input | 1 | Writes `wrData` into the holding register |
| wrData | input | 8 | Byte to transmit |
| modeSel | input | 4 | Mode field; 4'h1 selects bus-driver mode |
| oddParity | input | 1 | 1 selects odd parity, 0 selects even parity |
| guardBits | input | 8 | Number of idle bit periods after each character |
| manualRts | input | 1 | Level driven on `rts` in plain mode |
| txd | output | 1 | Serial line, idles high |
| txReady | output | 1 | Holding register is free |
| txEmpty | output | 1 | Nothing left to send |
| rts | output | 1 | Line-driver enable, or `manualRts` in plain mode |

## Verification
A write shows up in the cycle right after its clock edge: `txReady` and `txEmpty` go low, and in bus-driver mode `rts` rises. The start bit appears in the cycle after the next baud tick at which the shifter is free. Each later bit, each guard period and the final return to empty also take effect one cycle after the tick that ends the previous period. `rts` follows `modeSel` and `manualRts` in the same cycle.

The reference model advances on the same clock edge as the design, and outputs are compared at the following falling edge, so every timing above is checked at exactly its cycle. Writes are issued only while the model's holding register is empty, and the write-time checks sample the first falling edge after the write.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  // Value of the mode field that turns on line-driver control.
  localparam logic [3:0] BUS_MODE_CODE = 4'h1;

  // Strobes from the control to the datapath, one cycle wide.
  typedef struct packed {
    logic capture;   // take wrData into the holding register
    logic load;      // move the held byte into the shift register as a frame
    logic shift;     // advance to the next bit of the frame
  } txStrobe_t;
endpackage

// File: rtl/hdx_tx_ctrl.sv
module hdx_tx_ctrl
  import hdx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baudTick,
  input  logic               wrStrobe,
  input  logic [GUARD_W-1:0] guardBits,
  output txStrobe_t          strb,
  output logic               holdFull,
  output logic               shifterBusy
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GUARD} txState_t;

  txState_t           state;
  logic [CNT_W-1:0]   bitCnt;
  logic [GUARD_W-1:0] guardLatch;
  logic [GUARD_W-1:0] guardCnt;
  logic               slotEnds;

  // The current slot is the last one of the character, so the shifter is free at the next tick.
  always_comb begin
    slotEnds = 1'b0;
    unique case (state)
      ST_IDLE:  slotEnds = 1'b1;
      ST_SEND:  slotEnds = (bitCnt == LAST_BIT) && (guardLatch == '0);
      ST_GUARD: slotEnds = (guardCnt == GUARD_W'(1));
      default:  slotEnds = 1'b1;
    endcase
    strb.capture = wrStrobe;
    strb.load    = baudTick && slotEnds && holdFull;
    strb.shift   = baudTick && (state == ST_SEND);
  end

  assign shifterBusy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
    end else if (wrStrobe) begin
      holdFull <= 1'b1;
    end else if (strb.load) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      guardLatch <= '0;
      guardCnt   <= '0;
    end else if (strb.load) begin
      state      <= ST_SEND;
      bitCnt     <= '0;
      guardLatch <= guardBits;
    end else if (baudTick) begin
      unique case (state)
        ST_SEND: begin
          if (bitCnt == LAST_BIT) begin
            if (guardLatch != '0) begin
              state    <= ST_GUARD;
              guardCnt <= guardLatch;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        ST_GUARD: begin
          if (guardCnt == GUARD_W'(1)) state <= ST_IDLE;
          else                         guardCnt <= guardCnt - GUARD_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdx_tx_datapath.sv
module hdx_tx_datapath
  import hdx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              oddParity,
  output logic              txd
);
  localparam int FRAME_BITS = DATA_W + 3;

  logic [DATA_W-1:0]     holdData;
  logic [FRAME_BITS-1:0] shiftReg;
  logic                  parityBit;

  assign parityBit = oddParity ? ~(^holdData) : ^holdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdData <= '0;
    else if (strb.capture) holdData <= wrData;
  end

  // Bit 0 is on the line; after the stop bit has gone out, the register is all ones, so txd idles high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          shiftReg <= '1;
    else if (strb.load) shiftReg <= {1'b1, parityBit, holdData, 1'b0};
    else if (strb.shift) shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
  end

  assign txd = shiftReg[0];
endmodule

// File: rtl/hdx_uart_tx.sv
module hdx_uart_tx
  import hdx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baudTick,
  input  logic               wrStrobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [3:0]         modeSel,
  input  logic               oddParity,
  input  logic [GUARD_W-1:0] guardBits,
  input  logic               manualRts,
  output logic               txd,
  output logic               txReady,
  output logic               txEmpty,
  output logic               rts
);
  txStrobe_t strb;
  logic      holdFull;
  logic      shifterBusy;
  logic      busMode;

  hdx_tx_ctrl #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrStrobe(wrStrobe),
    .guardBits(guardBits), .strb(strb), .holdFull(holdFull), .shifterBusy(shifterBusy)
  );

  hdx_tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .oddParity(oddParity), .txd(txd)
  );

  assign busMode = (modeSel == BUS_MODE_CODE);
  assign txReady = !holdFull;
  assign txEmpty = !holdFull && !shifterBusy;
  assign rts     = busMode ? !txEmpty : manualRts;
endmodule

// File: rtl/hdx_uart_tx_chk.sv
module hdx_uart_tx_chk #(
  parameter int DATA_W  = 8,
  parameter int GUARD_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               baudTick,
  input logic               wrStrobe,
  input logic [DATA_W-1:0]  wrData,
  input logic [3:0]         modeSel,
  input logic               oddParity,
  input logic [GUARD_W-1:0] guardBits,
  input logic               manualRts,
  input logic               txd,
  input logic               txReady,
  input logic               txEmpty,
  input logic               rts
);
  p_rts_follows_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 4'h1) |-> (rts == !txEmpty));

  p_rts_manual_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 4'h1) |-> (rts == manualRts));

  p_txd_moves_on_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> $stable(txd));

  p_ready_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !txReady);

  p_empty_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !txEmpty);

  p_empty_line_high_r12: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txd);

  p_empty_implies_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txReady);
endmodule

bind hdx_uart_tx hdx_uart_tx_chk #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_chk (.*);

// File: tb/test_hdx_uart_tx.sv
`timescale 1ns/1ps
module test_hdx_uart_tx;
  localparam int TICK_DIV = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic [3:0] modeSel = 4'h0;
  logic       oddParity = 1'b0;
  logic [7:0] guardBits = '0;
  logic       manualRts = 1'b0;
  logic       txd, txReady, txEmpty, rts;

  always #4 clk = ~clk;  // 125 MHz

  hdx_uart_tx i_hdx_uart_tx (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrStrobe(wrStrobe), .wrData(wrData),
    .modeSel(modeSel), .oddParity(oddParity), .guardBits(guardBits), .manualRts(manualRts),
    .txd(txd), .txReady(txReady), .txEmpty(txEmpty), .rts(rts)
  );

  int    checks = 0;
  int    fails = 0;
  int    tickCnt = 0;
  string phaseTag = "R12";

  // Behavioural reference: one queue entry per remaining bit period on the line.
  int       lineQ[$];
  bit       mHold = 0;
  bit [7:0] mHoldVal = '0;

  function automatic void pushFrame(bit [7:0] d);
    lineQ.push_back(0);
    for (int i = 0; i < 8; i++) lineQ.push_back(int'(d[i]));
    lineQ.push_back(oddParity ? int'(~(^d)) : int'(^d));
    lineQ.push_back(1);
    for (int g = 0; g < int'(guardBits); g++) lineQ.push_back(1);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ.delete();
      mHold = 0;
    end else begin
      if (baudTick) begin
        if (lineQ.size() > 0) void'(lineQ.pop_front());
        if (lineQ.size() == 0 && mHold) begin
          pushFrame(mHoldVal);
          mHold = 0;
        end
      end
      if (wrStrobe) begin
        mHold = 1;
        mHoldVal = wrData;
      end
    end
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic eEmpty, eTxd, eRts;
    eEmpty = !mHold && (lineQ.size() == 0);
    eTxd   = (lineQ.size() > 0) ? logic'(lineQ[0]) : 1'b1;
    eRts   = (modeSel == 4'h1) ? !eEmpty : manualRts;
    check(phaseTag, "txd", txd, eTxd);
    check(phaseTag, "txReady", txReady, !mHold);
    check(phaseTag, "txEmpty", txEmpty, eEmpty);
    check(phaseTag, "rts", rts, eRts);
  endtask

  task automatic cycle();
    @(negedge clk);
    compareAll();
    wrStrobe = 1'b0;
    tickCnt++;
    baudTick = (tickCnt % TICK_DIV == 0);
  endtask

  task automatic writeByte(input logic [7:0] d);
    while (mHold) cycle();
    wrStrobe = 1'b1;
    wrData = d;
    cycle();
    check("R6", "txReady after write", txReady, 1'b0);
    check("R7", "txEmpty after write", txEmpty, 1'b0);
  endtask

  task automatic drain();
    while (mHold || lineQ.size() > 0) cycle();
    repeat (3) cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "txd in reset", txd, 1'b1);
    check("R12", "txReady in reset", txReady, 1'b1);
    check("R12", "txEmpty in reset", txEmpty, 1'b1);
    rstN = 1'b1;
    cycle();

    // R11: plain mode, rts tracks the software level
    phaseTag = "R11";
    for (int i = 0; i < 6; i++) begin
      manualRts = i[0];
      cycle();
    end

    // R4: plain frame, even parity, no guard
    phaseTag = "R4";
    manualRts = 1'b1;
    writeByte(8'hA5);
    drain();

    // R8: bus-driver mode, back-to-back characters with no guard
    phaseTag = "R8";
    modeSel = 4'h1;
    manualRts = 1'b0;
    writeByte(8'h3C);
    writeByte(8'hC3);
    drain();

    // R3: guard time of 4 holds the driver on
    phaseTag = "R3";
    guardBits = 8'd4;
    writeByte(8'h5A);
    drain();

    // R2: rts mirrors empty across another guarded character
    phaseTag = "R2";
    guardBits = 8'd2;
    writeByte(8'hF0);
    drain();

    // R10: write during the guard time waits for it to finish
    phaseTag = "R10";
    guardBits = 8'd3;
    writeByte(8'h81);
    while (lineQ.size() != 2) cycle();
    writeByte(8'h7E);
    drain();

    // R5: guard of 7 between two queued characters
    phaseTag = "R5";
    guardBits = 8'd7;
    writeByte(8'h12);
    writeByte(8'h34);
    drain();

    // R9: odd parity
    phaseTag = "R9";
    guardBits = 8'd0;
    oddParity = 1'b1;
    writeByte(8'h00);
    writeByte(8'h07);
    drain();

    // R1: a nonzero mode other than 4'h1 is plain mode
    phaseTag = "R1";
    oddParity = 1'b0;
    modeSel = 4'h9;
    manualRts = 1'b0;
    writeByte(8'hE1);
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule